// File: doc/BRIEF.md
# Masked Vector Lane Insert Unit

This block builds a new vector register value by taking a first source vector and overwriting one aligned chunk of it with a narrower second source. The chunk is 128 or 256 bits wide, and the low bits of an 8-bit immediate choose where it goes. A per-element write mask then decides, for each 32-bit or 64-bit element, whether the element takes this merged value, keeps the old destination element (merging), or becomes zero (zeroing). The active vector length is 256 or 512 bits inside a 512-bit register. Every bit at or above the active length is cleared.

A legacy mode is also provided. It always works at 256 bits with a 128-bit chunk and no masking. The result is registered. A valid strobe pulses one cycle after each accepted operation. An illegal mode combination raises an error flag and leaves the held destination unchanged.

Top module: `vec_lane_insert`

## Requirements
- R1: With a 128-bit chunk at 512-bit length, `imm[1:0]` picks the 128-bit slot that receives `src_b[127:0]`: slot n covers bits [128n+127:128n]. `imm[7:2]` has no effect.
- R2: With a 128-bit chunk at 256-bit length, only `imm[0]` picks the slot (0 = bits [127:0], 1 = bits [255:128]). `imm[7:1]` has no effect.
- R3: With a 256-bit chunk (512-bit length only), `imm[0]` = 0 writes `src_b[255:0]` to bits [255:0] and 1 writes it to bits [511:256]. `imm[7:1]` has no effect.
- R4: Every bit inside the active length and outside the inserted chunk is taken from the same position of `src_a`, when that element is written.
- R5: With `elem64` = 0, elements are 32 bits wide and element e is controlled by `kmask[e]`. With `elem64` = 1, elements are 64 bits wide and element e is controlled by `kmask[e]`: 4 bits are used at 256-bit length and 8 at 512-bit length.
- R6: An element takes the merged value when `mask_en` = 0 or its mask bit is 1. Otherwise it takes the matching `old_dst` element when `zero_mode` = 0, and zero when `zero_mode` = 1.
- R7: When the active length is 256 bits (`len512` = 0, or legacy mode), `dst[511:256]` is zero.
- R8: With `legacy` = 1 and `legacy_len` = 1, the block acts as a 128-bit insert at 256-bit length with masking off. `len512`, `elem64`, `chunk256`, `mask_en`, `zero_mode` and `kmask` are ignored.
- R9: An operation is illegal when `legacy` = 1 with `legacy_len` = 0, or when `legacy` = 0 with `chunk256` = 1 and `len512` = 0. For an illegal operation, `err` is 1 together with `out_valid`, and `dst` keeps its previous value.
- R10: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` = 1. `err` is 0 whenever `out_valid` is 0.
- R11: While `rst` is high at a clock edge, `out_valid`, `err` and `dst` are cleared to zero.
- R12: Mask bits at or above the active element count (16, 8 or 4) have no effect on `dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| src_a | input | 512 | First source vector |
| src_b | input | 256 | Chunk source; upper 128 bits unused for 128-bit chunks |
| old_dst | input | 512 | Previous destination, used by merging |
| imm | input | 8 | Position immediate |
| kmask | input | 16 | Per-element write mask |
| len512 | input | 1 | Vector length: 0 = 256, 1 = 512 |
| elem64 | input | 1 | Element width: 0 = 32, 1 = 64 |
| chunk256 | input | 1 | Chunk width: 0 = 128, 1 = 256 |
| mask_en | input | 1 | Apply the write mask |
| zero_mode | input | 1 | Masked-off elements become zero instead of old |
| legacy | input | 1 | Legacy unmasked 256-bit insert |
| legacy_len | input | 1 | Legacy length bit: 1 = 256 (legal), 0 = 128 (illegal) |
| out_valid | output | 1 | Result strobe |
| err | output | 1 | Illegal-operation flag |
| dst | output | 512 | Registered destination |

## Verification
Immediates with their upper bits set show whether placement looks only at the bits it should. Each chunk position is tried at both lengths and both chunk widths. Masks with mixed bit patterns, all-ones and all-zeros masks separate merging from zeroing and show whether the mask is indexed correctly per element width. Masks with bits set above the element count show whether the block wrongly uses them. Illegal combinations placed after a legal result show whether the held destination survives. A long run of random sources, immediates and masks over every legal mode is compared against a bit-level model.

// File: rtl/lvi_pkg.sv
package lvi_pkg;
  localparam int REG_W  = 512;
  localparam int CHUNK_W = 128;
  localparam int SLOT_W = 32;
  localparam int IMM_W  = 8;

  typedef struct packed {
    logic len512;
    logic elem64;
    logic chunk256;
    logic mask_en;
    logic zero_mode;
  } lvi_mode_t;
endpackage

// File: rtl/lvi_mode_check.sv
module lvi_mode_check
  import lvi_pkg::*;
(
  input  logic      legacy,
  input  logic      legacy_len,
  input  lvi_mode_t mode_in,
  output lvi_mode_t mode_eff,
  output logic      legal
);
  always_comb begin
    if (legacy) begin
      mode_eff.len512    = 1'b0;
      mode_eff.elem64    = 1'b0;
      mode_eff.chunk256  = 1'b0;
      mode_eff.mask_en   = 1'b0;
      mode_eff.zero_mode = 1'b0;
      legal              = legacy_len;
    end else begin
      mode_eff = mode_in;
      legal    = !(mode_in.chunk256 && !mode_in.len512);
    end
  end
endmodule

// File: rtl/lvi_place.sv
module lvi_place #(
  parameter int CW = 128,
  parameter int NQ = 4,
  localparam int IDX_W = $clog2(NQ)
) (
  input  logic [NQ*CW-1:0] src_a,
  input  logic [2*CW-1:0]  src_b,
  input  logic [IDX_W-1:0] idx,
  input  logic             wide,
  output logic [NQ*CW-1:0] merged
);
  for (genvar q = 0; q < NQ; q++) begin : g_quarter
    localparam int HALF = q / 2;
    localparam int PART = q % 2;
    logic hit_narrow, hit_wide;
    assign hit_narrow = !wide && (idx == IDX_W'(q));
    assign hit_wide   = wide && (idx[0] == HALF[0]);
    always_comb begin
      if (hit_narrow)
        merged[q*CW +: CW] = src_b[CW-1:0];
      else if (hit_wide)
        merged[q*CW +: CW] = src_b[PART*CW +: CW];
      else
        merged[q*CW +: CW] = src_a[q*CW +: CW];
    end
  end
endmodule

// File: rtl/lvi_mask.sv
module lvi_mask #(
  parameter int SW = 32,
  parameter int NS = 16
) (
  input  logic [NS*SW-1:0] merged,
  input  logic [NS*SW-1:0] old_dst,
  input  logic [NS-1:0]    kmask,
  input  logic             elem64,
  input  logic             len512,
  input  logic             mask_en,
  input  logic             zero_mode,
  output logic [NS*SW-1:0] result
);
  for (genvar s = 0; s < NS; s++) begin : g_slot
    localparam int PAIR = s / 2;
    logic mbit, active, take;
    assign mbit   = elem64 ? kmask[PAIR] : kmask[s];
    assign active = len512 || (s < NS / 2);
    assign take   = !mask_en || mbit;
    always_comb begin
      if (!active)
        result[s*SW +: SW] = '0;
      else if (take)
        result[s*SW +: SW] = merged[s*SW +: SW];
      else if (zero_mode)
        result[s*SW +: SW] = '0;
      else
        result[s*SW +: SW] = old_dst[s*SW +: SW];
    end
  end
endmodule

// File: rtl/vec_lane_insert.sv
module vec_lane_insert
  import lvi_pkg::*;
#(
  parameter int VW = REG_W,
  parameter int CW = CHUNK_W,
  parameter int SW = SLOT_W,
  parameter int IW = IMM_W,
  localparam int NQ = VW / CW,
  localparam int NS = VW / SW,
  localparam int IDX_W = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [VW-1:0] src_a,
  input  logic [2*CW-1:0] src_b,
  input  logic [VW-1:0] old_dst,
  input  logic [IW-1:0] imm,
  input  logic [NS-1:0] kmask,
  input  logic          len512,
  input  logic          elem64,
  input  logic          chunk256,
  input  logic          mask_en,
  input  logic          zero_mode,
  input  logic          legacy,
  input  logic          legacy_len,
  output logic          out_valid,
  output logic          err,
  output logic [VW-1:0] dst
);
  lvi_mode_t mode_in, mode_eff;
  logic legal;
  logic [IDX_W-1:0] idx;
  logic [VW-1:0] merged, result;

  assign mode_in = '{len512: len512, elem64: elem64, chunk256: chunk256,
                     mask_en: mask_en, zero_mode: zero_mode};

  lvi_mode_check u_mode (
    .legacy(legacy), .legacy_len(legacy_len), .mode_in(mode_in),
    .mode_eff(mode_eff), .legal(legal)
  );

  // position index: full low bits at full length, one bit otherwise
  always_comb begin
    idx = imm[IDX_W-1:0];
    if (!mode_eff.len512 || mode_eff.chunk256)
      idx[IDX_W-1:1] = '0;
  end

  lvi_place #(.CW(CW), .NQ(NQ)) u_place (
    .src_a(src_a), .src_b(src_b), .idx(idx), .wide(mode_eff.chunk256),
    .merged(merged)
  );

  lvi_mask #(.SW(SW), .NS(NS)) u_mask (
    .merged(merged), .old_dst(old_dst), .kmask(kmask),
    .elem64(mode_eff.elem64), .len512(mode_eff.len512),
    .mask_en(mode_eff.mask_en), .zero_mode(mode_eff.zero_mode),
    .result(result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      err       <= 1'b0;
      dst       <= '0;
    end else begin
      out_valid <= in_valid;
      err       <= in_valid && !legal;
      if (in_valid && legal)
        dst <= result;
    end
  end
endmodule

// File: rtl/lvi_checker.sv
module lvi_checker #(
  parameter int VW = 512
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          len512,
  input logic          chunk256,
  input logic          legacy,
  input logic          legacy_len,
  input logic          out_valid,
  input logic          err,
  input logic [VW-1:0] dst
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R10
  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    err |-> out_valid); // R10
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && err && !$past(rst)) |-> $stable(dst)); // R9
  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ((legacy && !legacy_len) || (!legacy && chunk256 && !len512))) |=> err); // R9
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (legacy ? legacy_len : (!len512 && !chunk256))) |=> (dst[VW-1:VW/2] == '0)); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !err && dst == '0)); // R11
endmodule

bind vec_lane_insert lvi_checker #(.VW(VW)) u_lvi_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .len512(len512),
  .chunk256(chunk256), .legacy(legacy), .legacy_len(legacy_len),
  .out_valid(out_valid), .err(err), .dst(dst)
);

// File: tb/vec_lane_insert_bench.sv
module vec_lane_insert_bench;
  logic clk = 1'b0;
  logic rst;
  logic in_valid;
  logic [511:0] src_a, old_dst, dst;
  logic [255:0] src_b;
  logic [7:0] imm;
  logic [15:0] kmask;
  logic len512, elem64, chunk256, mask_en, zero_mode, legacy, legacy_len;
  logic out_valid, err;

  int total = 0;
  int bad = 0;
  logic [511:0] held;

  always #5 clk = ~clk;

  vec_lane_insert u_vec_lane_insert (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .old_dst(old_dst), .imm(imm), .kmask(kmask), .len512(len512),
    .elem64(elem64), .chunk256(chunk256), .mask_en(mask_en),
    .zero_mode(zero_mode), .legacy(legacy), .legacy_len(legacy_len),
    .out_valid(out_valid), .err(err), .dst(dst)
  );

  typedef struct packed {
    logic       lg, lgl, l512, e64, c256, men, zm;
    logic [7:0] im;
    logic [15:0] km;
    logic       xerr;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TABLE [NV] = '{
    '{0,0,1,0,0,0,0, 8'hFE, 16'h0000, 0, 4'd1},  // R1 slot 2, high imm bits set
    '{0,0,1,0,0,0,0, 8'h03, 16'h0000, 0, 4'd1},  // R1 slot 3
    '{0,0,0,0,0,0,0, 8'hFF, 16'h0000, 0, 4'd2},  // R2 imm[1] ignored
    '{0,0,0,0,0,0,0, 8'h02, 16'h0000, 0, 4'd2},  // R2 low half
    '{0,0,1,0,1,0,0, 8'h01, 16'h0000, 0, 4'd3},  // R3 high half
    '{0,0,1,0,1,0,0, 8'hFE, 16'h0000, 0, 4'd3},  // R3 low half
    '{0,0,1,0,0,1,0, 8'h01, 16'hA5C3, 0, 4'd6},  // R6 merging 32-bit
    '{0,0,1,0,0,1,1, 8'h02, 16'h0F0F, 0, 4'd6},  // R6 zeroing 32-bit
    '{0,0,1,1,0,1,0, 8'h03, 16'h0096, 0, 4'd5},  // R5 64-bit elements
    '{0,0,1,1,1,1,1, 8'h00, 16'hFF5A, 0, 4'd12}, // R12 upper mask ignored
    '{0,0,0,0,0,1,1, 8'h01, 16'hFF33, 0, 4'd12}, // R12 256-bit length
    '{0,0,0,1,0,1,0, 8'h01, 16'hFFF5, 0, 4'd7},  // R7 upper cleared
    '{0,0,1,0,0,1,1, 8'h00, 16'hFFFF, 0, 4'd6},  // R6 all-ones mask
    '{0,0,1,1,0,1,0, 8'h01, 16'h0000, 0, 4'd6},  // R6 all-zeros mask merging
    '{1,1,1,1,1,1,1, 8'h81, 16'h0000, 0, 4'd8},  // R8 legacy ignores mode bits
    '{1,0,1,0,0,0,0, 8'h00, 16'hFFFF, 1, 4'd9},  // R9 legacy bad length
    '{0,0,0,0,1,0,0, 8'h01, 16'hFFFF, 1, 4'd9}   // R9 wide chunk at 256
  };

  function automatic logic [511:0] model(
      input logic [511:0] a, input logic [255:0] b, input logic [511:0] od,
      input logic [7:0] im, input logic [15:0] km, input logic lg,
      input logic l512, input logic e64, input logic c256,
      input logic men, input logic zm);
    logic [511:0] t, r;
    int vl, cw, ew, pos;
    if (lg) begin l512 = 0; e64 = 0; c256 = 0; men = 0; zm = 0; end
    vl = l512 ? 512 : 256;
    cw = c256 ? 256 : 128;
    ew = e64 ? 64 : 32;
    pos = (int'(im) % (vl / cw)) * cw;
    t = a;
    for (int k = 0; k < cw; k++) t[pos + k] = b[k];
    r = '0;
    for (int e = 0; e < vl / ew; e++) begin
      for (int k = 0; k < ew; k++) begin
        if (!men || km[e]) r[e*ew + k] = t[e*ew + k];
        else if (!zm)      r[e*ew + k] = od[e*ew + k];
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic ok,
                       input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic randomize_data();
    for (int w = 0; w < 16; w++) begin
      src_a[w*32 +: 32]   = $urandom;
      old_dst[w*32 +: 32] = $urandom;
    end
    for (int w = 0; w < 8; w++) src_b[w*32 +: 32] = $urandom;
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic run_op(input string tag, input logic xerr);
    logic [511:0] exp;
    @(negedge clk);
    in_valid = 1'b1;
    exp = xerr ? held : model(src_a, src_b, old_dst, imm, kmask, legacy,
                               len512, elem64, chunk256, mask_en, zero_mode);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, out_valid === 1'b1, {511'd0, out_valid}, 512'd1);
    check({tag, " err"}, err === xerr, {511'd0, err}, {511'd0, xerr});
    check({tag, " dst"}, dst === exp, dst, exp);
    held = dst;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; src_a = '0; src_b = '0; old_dst = '0;
    imm = '0; kmask = '0; len512 = 0; elem64 = 0; chunk256 = 0;
    mask_en = 0; zero_mode = 0; legacy = 0; legacy_len = 0;
    held = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset valid", out_valid === 1'b0, {511'd0, out_valid}, 512'd0);
    check("R11 reset err", err === 1'b0, {511'd0, err}, 512'd0);
    check("R11 reset dst", dst === '0, dst, 512'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 idle valid", out_valid === 1'b0, {511'd0, out_valid}, 512'd0);

    for (int i = 0; i < NV; i++) begin
      randomize_data();
      {legacy, legacy_len, len512, elem64, chunk256, mask_en, zero_mode} =
        {TABLE[i].lg, TABLE[i].lgl, TABLE[i].l512, TABLE[i].e64,
         TABLE[i].c256, TABLE[i].men, TABLE[i].zm};
      imm = TABLE[i].im;
      kmask = TABLE[i].km;
      run_op($sformatf("R%0d table[%0d]", TABLE[i].req, i), TABLE[i].xerr);
    end

    // R4 R1 R2 R3 R5 R6 R7 R8: random legal modes against the model
    for (int i = 0; i < 300; i++) begin
      randomize_data();
      legacy = ($urandom % 6) == 0;
      legacy_len = 1'b1;
      len512 = $urandom; elem64 = $urandom; mask_en = $urandom;
      zero_mode = $urandom;
      chunk256 = len512 ? 1'($urandom) : 1'b0;
      imm = $urandom; kmask = $urandom;
      run_op("R4 random", 1'b0);
    end

    // R9 illegal operation right after a legal one keeps dst
    randomize_data();
    legacy = 0; len512 = 0; chunk256 = 1; mask_en = 0;
    run_op("R9 hold", 1'b1);

    // R10 no strobe without a request
    @(negedge clk);
    check("R10 no strobe", out_valid === 1'b0, {511'd0, out_valid}, 512'd0);
    check("R10 no err", err === 1'b0, {511'd0, err}, 512'd0);

    // R11 reset mid-run clears the held result
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11 mid reset dst", dst === '0, dst, 512'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule